// File: doc/BRIEF.md
# Converter Analog Settling Sequencer

This block decides how long a data converter must wait for its analog helpers to wake up before a conversion may sample. Each helper (the converter core, an internal voltage reference, the temperature-sensor input path and the comparator-DAC input path) has its own wake-up time. The helpers warm up side by side, so the wait is the largest of the delays that the current setup uses. That wait changes with the low-latency mode, with whether the block has just been enabled, and with how the reference selection moved since the last conversion.

When a request is accepted, the block raises a busy flag for the whole wait, counted in whole microseconds from a tick divided down from the system clock. It then pulses a start strobe and holds a sampling window open for the programmed sample count plus one half converter-clock cycle, counted in half-cycle units. A setup that uses the internal reference with a sample count too short for it is flagged as an error, and requests are refused while the flag is up.

Top module: `adc_settle_seq`

## Requirements
- R1: `cfg_err_o` is high exactly when `ref_int_i` is 1 and 2·`samp_dur_i`+1 is below 4·TICK_DIV/HALF_DIV − 2 half-cycles (with defaults: error for `samp_dur_i` ≤ 6, none for 7; never with an external reference).
- R2: A request is accepted only when `en_i` is high, `cfg_err_o` is low and neither busy nor sampling is high. Any other request has no effect on `busy_o`, `sampling_o` or `start_o`.
- R3: With low latency off, an external reference and no special input, busy lasts 6 µs (6·TICK_DIV cycles).
- R4: An internal reference settles for 40 µs with low latency off, on the first conversion after enable, and when it follows an external reference.
- R5: When this conversion and the previous one both run in low-latency mode with an unchanged setup after warm-up, the core needs 0 µs and an internal reference 2 µs. A zero wait skips busy and starts sampling in the cycle after the request.
- R6: Changing the internal voltage code (`ref_code_i`) while the internal reference stays selected costs 20 µs in either mode.
- R7: The temperature-sensor input costs 40 µs, or 0 µs in the reduced low-latency case of R5.
- R8: The comparator-DAC input costs 20 µs in every mode.
- R9: With several helpers in use, the wait is the maximum of their delays, not the sum.
- R10: `busy_o` is high for exactly the wait. `start_o` is a single-cycle pulse in the first sampling cycle, and busy and sampling are never high together.
- R11: `sampling_o` stays high for (2·`samp_dur_i`+1)·HALF_DIV cycles.
- R12: Dropping `en_i` clears busy and sampling on the next cycle. The next conversion after re-enable pays the full first-enable times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Converter enable |
| req_i | input | 1 | Conversion request, one cycle |
| lowlat_i | input | 1 | Keep helpers powered between conversions |
| ref_int_i | input | 1 | 1: internal reference, 0: external |
| ref_code_i | input | REFSEL_W | Internal reference voltage code |
| temp_sel_i | input | 1 | Temperature-sensor input selected |
| dac_sel_i | input | 1 | Comparator-DAC input selected |
| samp_dur_i | input | SD_W | Programmed sample count |
| busy_o | output | 1 | Settling in progress |
| start_o | output | 1 | Sampling begins (one-cycle pulse) |
| sampling_o | output | 1 | Sampling window open |
| cfg_err_o | output | 1 | Sample count too short for internal reference |

## Verification
The assertions watch, on every cycle, that busy and sampling never overlap, that the start strobe marks the first sampling cycle only, that a refused or disabled request leaves both phases idle, and that the timers never jump upward on their own. The length of each wait (which helper wins the maximum, the reduced low-latency values, the 20 µs code swap and the full cost after re-enable) depends on the history of conversions, so only the bench's directed sequences can show it by measuring busy and sampling lengths against values worked out from the requirements.

// File: rtl/adc_settle_pkg.sv
package adc_settle_pkg;

   // width of the internal reference voltage code
   localparam int REFSEL_W = 2;

   // setup that a conversion ran with, kept to judge the next one
   typedef struct packed {
      logic                ref_int;
      logic [REFSEL_W-1:0] code;
      logic                temp;
      logic                dac;
   } conv_setup_t;

   localparam int NUM_HELPERS = 4;

endpackage

// File: rtl/adc_step_timer.sv
module adc_step_timer #(
   parameter int DIV = 4,
   parameter int CW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          abort_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          active_o,
   output logic          last_o
);

   logic [CW-1:0] cnt_q;
   logic          step;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("adc_step_timer: DIV must be at least 1");
      end
      if (CW < 1) begin : g_bad_cw
         $error("adc_step_timer: CW must be at least 1");
      end

      if (DIV == 1) begin : g_nodiv
         assign step = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (abort_i || load_i || (cnt_q == '0)) begin
               div_q <= '0;
            end else if (div_q == DW'(DIV - 1)) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         assign step = (div_q == DW'(DIV - 1));
      end
   endgenerate

   assign active_o = (cnt_q != '0);
   assign last_o   = active_o && step && (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (abort_i) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (active_o && step) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // R11
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !abort_i && !load_i) |=>
         ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)));

endmodule

// File: rtl/adc_settle_calc.sv
module adc_settle_calc
   import adc_settle_pkg::*;
#(
   parameter int DW         = 8,
   parameter int CORE_US    = 6,
   parameter int CORE_LL_US = 0,
   parameter int REF_US     = 40,
   parameter int REF_LL_US  = 2,
   parameter int SWAP_US    = 20,
   parameter int TEMP_US    = 40,
   parameter int TEMP_LL_US = 0,
   parameter int DAC_US     = 20
) (
   input  logic          reduced_i,
   input  logic          ref_int_i,
   input  logic          ref_swap_i,
   input  logic          temp_i,
   input  logic          dac_i,
   output logic [DW-1:0] wait_o
);

   localparam int LIMIT = 1 << DW;

   generate
      if (CORE_US >= LIMIT || REF_US >= LIMIT || SWAP_US >= LIMIT ||
          TEMP_US >= LIMIT || DAC_US >= LIMIT || REF_LL_US >= LIMIT ||
          CORE_LL_US >= LIMIT || TEMP_LL_US >= LIMIT) begin : g_bad_dw
         $error("adc_settle_calc: a delay does not fit in DW bits");
      end
   endgenerate

   logic [DW-1:0] dly [NUM_HELPERS];

   always_comb begin
      // converter core
      dly[0] = reduced_i ? DW'(CORE_LL_US) : DW'(CORE_US);
      // reference: a code swap takes precedence over the steady cases
      if (!ref_int_i)      dly[1] = '0;
      else if (ref_swap_i) dly[1] = DW'(SWAP_US);
      else if (reduced_i)  dly[1] = DW'(REF_LL_US);
      else                 dly[1] = DW'(REF_US);
      // temperature-sensor path
      if (!temp_i)         dly[2] = '0;
      else if (reduced_i)  dly[2] = DW'(TEMP_LL_US);
      else                 dly[2] = DW'(TEMP_US);
      // comparator-DAC path, same cost in every mode
      dly[3] = dac_i ? DW'(DAC_US) : '0;
   end

   always_comb begin
      wait_o = '0;
      for (int k = 0; k < NUM_HELPERS; k++) begin
         if (dly[k] > wait_o) wait_o = dly[k];
      end
   end

endmodule

// File: rtl/adc_settle_seq.sv
module adc_settle_seq
   import adc_settle_pkg::*;
#(
   parameter int TICK_DIV   = 4,
   parameter int HALF_DIV   = 1,
   parameter int SD_W       = 8,
   parameter int DW         = 8,
   parameter int CORE_US    = 6,
   parameter int REF_US     = 40,
   parameter int REF_LL_US  = 2,
   parameter int SWAP_US    = 20,
   parameter int TEMP_US    = 40,
   parameter int DAC_US     = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                req_i,
   input  logic                lowlat_i,
   input  logic                ref_int_i,
   input  logic [REFSEL_W-1:0] ref_code_i,
   input  logic                temp_sel_i,
   input  logic                dac_sel_i,
   input  logic [SD_W-1:0]     samp_dur_i,
   output logic                busy_o,
   output logic                start_o,
   output logic                sampling_o,
   output logic                cfg_err_o
);

   // shortest sampling window with the internal reference, in half-cycles
   localparam int MIN_HALF = (4 * TICK_DIV) / HALF_DIV - 2;
   localparam int HW       = SD_W + 1;

   generate
      if (TICK_DIV < 1 || HALF_DIV < 1) begin : g_bad_div
         $error("adc_settle_seq: dividers must be at least 1");
      end
      if ((TICK_DIV % HALF_DIV) != 0) begin : g_bad_ratio
         $error("adc_settle_seq: TICK_DIV must be a multiple of HALF_DIV");
      end
   endgenerate

   conv_setup_t   cur_setup, prev_q;
   logic          prev_ll_q, warm_q, start_q;
   logic [HW-1:0] half_len;
   logic [DW-1:0] wait_us;
   logic          settle_act, settle_last, samp_act, samp_last;
   logic          idle, accept, reduced, ref_swap;
   logic          settle_load, samp_load;

   assign cur_setup = '{ref_int: ref_int_i, code: ref_code_i,
                        temp: temp_sel_i, dac: dac_sel_i};

   // sampling window length in half converter-clock cycles
   assign half_len  = {samp_dur_i, 1'b1};
   assign cfg_err_o = ref_int_i && (int'(half_len) < MIN_HALF);

   assign idle   = !settle_act && !samp_act;
   assign accept = en_i && req_i && !cfg_err_o && idle;

   assign reduced  = lowlat_i && prev_ll_q && warm_q && (cur_setup == prev_q);
   assign ref_swap = warm_q && prev_q.ref_int && ref_int_i &&
                     (prev_q.code != ref_code_i);

   adc_settle_calc #(
      .DW(DW), .CORE_US(CORE_US), .CORE_LL_US(0), .REF_US(REF_US),
      .REF_LL_US(REF_LL_US), .SWAP_US(SWAP_US), .TEMP_US(TEMP_US),
      .TEMP_LL_US(0), .DAC_US(DAC_US)
   ) calc_i (
      .reduced_i (reduced),
      .ref_int_i (ref_int_i),
      .ref_swap_i(ref_swap),
      .temp_i    (temp_sel_i),
      .dac_i     (dac_sel_i),
      .wait_o    (wait_us)
   );

   assign settle_load = accept && (wait_us != '0);
   assign samp_load   = (accept && (wait_us == '0)) || settle_last;

   adc_step_timer #(.DIV(TICK_DIV), .CW(DW)) settle_tmr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_i   (!en_i),
      .load_i    (settle_load),
      .load_val_i(wait_us),
      .active_o  (settle_act),
      .last_o    (settle_last)
   );

   adc_step_timer #(.DIV(HALF_DIV), .CW(HW)) samp_tmr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort_i   (!en_i),
      .load_i    (samp_load),
      .load_val_i(half_len),
      .active_o  (samp_act),
      .last_o    (samp_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= '0;
         prev_ll_q <= 1'b0;
         warm_q    <= 1'b0;
         start_q   <= 1'b0;
      end else begin
         start_q <= samp_load && en_i;
         if (!en_i) begin
            warm_q <= 1'b0;
         end else if (samp_load) begin
            warm_q <= 1'b1;
         end
         if (accept) begin
            prev_q    <= cur_setup;
            prev_ll_q <= lowlat_i;
         end
      end
   end

   assign busy_o     = settle_act;
   assign sampling_o = samp_act;
   assign start_o    = start_q;

   // R10
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && sampling_o));

   // R10
   start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (sampling_o && !$past(sampling_o)));

   // R2
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && cfg_err_o && !busy_o && !sampling_o) |=>
         (!busy_o && !sampling_o && !start_o));

   // R12
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!busy_o && !sampling_o && !start_o));

   // R11
   samp_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_last && en_i && !settle_last) |=> !sampling_o);

endmodule

// File: tb/adc_settle_seq_tb_top.sv
module adc_settle_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TICK       = 4;
   localparam int WIN        = 260;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, req = 1'b0, ll = 1'b0, rint = 1'b0;
   logic [1:0] rcode = 2'd0;
   logic       tsel = 1'b0, dsel = 1'b0;
   logic [7:0] sdur = 8'd10;
   logic       busy, start, samp, err;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_settle_seq dut_i (
      .clk(clk), .rst_n(rst_n), .en_i(en), .req_i(req), .lowlat_i(ll),
      .ref_int_i(rint), .ref_code_i(rcode), .temp_sel_i(tsel),
      .dac_sel_i(dsel), .samp_dur_i(sdur), .busy_o(busy), .start_o(start),
      .sampling_o(samp), .cfg_err_o(err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // issue one request and measure busy, sampling and start placement
   task automatic conv(input int exp_us, input int exp_samp, input string tag);
      int nb = 0, ns = 0, nst = 0, st_at = -1;
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      for (int i = 0; i < WIN; i++) begin
         if (busy) nb++;
         if (samp) ns++;
         if (start) begin
            nst++;
            if (st_at < 0) st_at = i;
         end
         @(negedge clk);
      end
      chk(nb == exp_us * TICK, {tag, " busy cycles"}, nb, exp_us * TICK);
      chk(ns == exp_samp, {tag, " R11 sampling cycles"}, ns, exp_samp);
      chk(nst == 1, {tag, " R10 start pulses"}, nst, 1);
      chk(st_at == exp_us * TICK, {tag, " R10 start position"}, st_at, exp_us * TICK);
   endtask

   task automatic t_reset;
      chk(!busy && !samp && !start, "R10 reset idle", busy + samp + start, 0);
   endtask

   task automatic t_err;
      en = 1'b1; rint = 1'b1; sdur = 8'd6;
      @(negedge clk) chk(err == 1'b1, "R1 short count flagged", err, 1);
      sdur = 8'd7;
      @(negedge clk) chk(err == 1'b0, "R1 minimum count accepted", err, 0);
      rint = 1'b0; sdur = 8'd0;
      @(negedge clk) chk(err == 1'b0, "R1 external never flagged", err, 0);
   endtask

   task automatic t_reject;
      int seen = 0;
      en = 1'b0; rint = 1'b0; sdur = 8'd10;
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      for (int i = 0; i < 20; i++) begin
         seen += busy + samp + start;
         @(negedge clk);
      end
      chk(seen == 0, "R2 disabled request ignored", seen, 0);
      en = 1'b1; rint = 1'b1; sdur = 8'd6;
      seen = 0;
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      for (int i = 0; i < 20; i++) begin
         seen += busy + samp + start;
         @(negedge clk);
      end
      chk(seen == 0, "R2 error request ignored", seen, 0);
      sdur = 8'd10;
   endtask

   task automatic t_core;
      ll = 1'b0; rint = 1'b0; tsel = 1'b0; dsel = 1'b0; sdur = 8'd10;
      conv(6, 21, "R3 core only");
      sdur = 8'd3;
      conv(6, 7, "R3 short window");
      sdur = 8'd10;
   endtask

   task automatic t_ref;
      ll = 1'b0; rint = 1'b1; rcode = 2'd0;
      conv(40, 21, "R4 internal ref");
      conv(40, 21, "R4 internal ref again");
      ll = 1'b1;
      conv(40, 21, "R5 first low-latency");
      conv(2, 21, "R5 reduced internal ref");
      rcode = 2'd1;
      conv(20, 21, "R6 code swap");
      conv(2, 21, "R5 reduced after swap");
      rint = 1'b0;
      conv(6, 21, "R3 ref removed");
      conv(0, 21, "R5 zero wait");
   endtask

   task automatic t_inputs;
      ll = 1'b1; tsel = 1'b1;
      conv(40, 21, "R7 temp full");
      conv(0, 21, "R7 temp reduced");
      tsel = 1'b0; dsel = 1'b1;
      conv(20, 21, "R8 dac first");
      conv(20, 21, "R8 dac reduced mode");
      ll = 1'b0; tsel = 1'b1;
      conv(40, 21, "R9 temp and dac");
      ll = 1'b1; tsel = 1'b0; rint = 1'b1; rcode = 2'd2;
      conv(40, 21, "R4 external to internal");
      conv(20, 21, "R9 ref and dac reduced");
   endtask

   task automatic t_abort;
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b1, "R12 busy before abort", busy, 1);
      en = 1'b0;
      @(negedge clk);
      chk(!busy && !samp, "R12 abort clears", busy + samp, 0);
      en = 1'b1;
      @(negedge clk);
      conv(40, 21, "R12 full after re-enable");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_err();
      t_reject();
      t_core();
      t_ref();
      t_inputs();
      t_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule